// File: doc/BRIEF.md
# Decoded Instruction Filter Cache

This block is a small direct-mapped store of already-decoded instructions placed in front of the instruction cache. When the fetch stage presents a program counter, the block answers in the same cycle with a hit flag, the stored decoded word and a learned follow-on address for the sector. On a hit the fetch stage can skip both the instruction-cache read and the decode step. On a miss the instruction is fetched and decoded elsewhere, and the decoder writes the decoded word back through the fill port.

Each sector covers four consecutive 4-byte instructions and stores one 64-bit decoded word per instruction. The sector carries a tag, a sector valid bit, a per-instruction valid mask and a next address. A steering output tells the fetch stage where to look for the following fetch. It points at this cache when the two most recent lookups carried the same tag, which indicates a tight loop or a straight-line run. When the tags differ, a change of control path is assumed and the next fetch is steered to the instruction cache. Five event counters track accesses, hits, misses, correct steerings and wrong steerings.

Top module: `dfc_top`

## Requirements
- R1: A synchronous reset invalidates every sector, so the first lookup after reset misses. It also drives the steering output low and clears all five counters to zero.
- R2: The lookup address is split as follows: bits [1:0] select the byte and are ignored, bits [3:2] select the instruction within the sector, bits [8:4] select the sector and bits [31:9] form the tag.
- R3: A lookup hits in the same cycle when the sector is valid, its tag matches and the addressed instruction's valid bit is set. The word output then carries the last word filled for that instruction.
- R4: On a miss, or when no lookup is presented, the hit flag is 0 and both the word output and the next-address output are 0.
- R5: A fill whose tag matches a valid sector sets only the addressed instruction's valid bit and writes its word. The other instructions of that sector keep hitting with their old words.
- R6: A fill to an invalid sector, or to a sector with a different tag, takes over the sector. It writes the new tag, clears every other instruction's valid bit and resets the sector's next address to 0.
- R7: After each lookup, the steering output becomes 1 when that lookup's tag equals the tag of the previous lookup since reset, and 0 otherwise. It holds its value through cycles without a lookup.
- R8: When a lookup's line address (bits [31:4]) differs from the previous lookup's line and the previous lookup hit, the previous sector's next address is set to the current lookup address. This does not happen if a fill targets that sector in the same cycle, in which case the fill takes priority. On a hit, the next-address output shows the sector's stored next address.
- R9: The access counter adds one for each lookup. The hit or the miss counter adds one according to the hit flag, and the new counts are visible after the clock edge.
- R10: The correct-steering counter adds one for each lookup whose steering value, as seen during that lookup, equals its hit flag. The wrong-steering counter adds one for every other lookup.
- R11: A lookup and a fill in the same cycle see the sector contents from before that cycle's fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookup_valid | input | 1 | Fetch lookup present |
| lookup_pc | input | 32 | Fetch address |
| hit_o | output | 1 | Lookup hit |
| word_o | output | 64 | Decoded word on hit, else 0 |
| next_pc_o | output | 32 | Stored next address of the hit sector, else 0 |
| steer_dfc_o | output | 1 | 1: next fetch goes to this cache, 0: to the instruction cache |
| fill_valid | input | 1 | Decoded word write present |
| fill_pc | input | 32 | Address of the decoded instruction |
| fill_word | input | 64 | Decoded instruction word |
| cnt_access_o | output | 32 | Lookup count |
| cnt_hit_o | output | 32 | Hit count |
| cnt_miss_o | output | 32 | Miss count |
| cnt_pred_ok_o | output | 32 | Correct steering count |
| cnt_pred_bad_o | output | 32 | Wrong steering count |

## Verification
The hit flag, word and next address come from combinational logic on the registered sector state. They are due in the cycle of the lookup itself, so the bench drives each operation just after a falling edge and samples these outputs a few nanoseconds later, before the next rising edge. Fills, link updates, the steering bit and the counters all take effect at the rising edge that ends the operation. The bench therefore reads the steering bit at the start of the following operation and reads the counters only after an idle cycle. Its shadow model is updated at the point that matches that edge, so expected values always describe the state seen at the moment of sampling.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int PC_W    = 32;
  localparam int NUM_CNT = 5;

  typedef logic [PC_W-1:0] pc_t;

  typedef enum int {
    CNT_ACC  = 0,
    CNT_HIT  = 1,
    CNT_MISS = 2,
    CNT_POK  = 3,
    CNT_PBAD = 4
  } cnt_sel_e;

  // Extract a w-bit field starting at bit lo of an address.
  function automatic pc_t pc_field(input pc_t pc, input int lo, input int w);
    pc_t mask;
    mask = (w >= PC_W) ? '1 : ((pc_t'(1) << w) - pc_t'(1));
    return (pc >> lo) & mask;
  endfunction
endpackage

// File: rtl/dfc_sectors.sv
module dfc_sectors
  import dfc_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int SLOT_W = 2,
  parameter int OFS_W  = 2,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_v,
  input  pc_t               lk_pc,
  input  logic              fl_v,
  input  pc_t               fl_pc,
  input  logic [WORD_W-1:0] fl_word,
  output logic              hit,
  output logic [WORD_W-1:0] word,
  output pc_t               nxt,
  output logic              evt_replace,
  output logic              evt_link
);
  localparam int SECTORS = 1 << IDX_W;
  localparam int SLOTS   = 1 << SLOT_W;
  localparam int LINE_LO = OFS_W + SLOT_W;
  localparam int TAG_LO  = LINE_LO + IDX_W;
  localparam int TAG_W   = PC_W - TAG_LO;
  localparam int LINE_W  = PC_W - LINE_LO;

  logic [SECTORS-1:0] sect_v;
  logic [TAG_W-1:0]   sect_tag  [SECTORS];
  logic [SLOTS-1:0]   slot_v    [SECTORS];
  pc_t                sect_next [SECTORS];
  logic [WORD_W-1:0]  words     [SECTORS][SLOTS];

  logic [IDX_W-1:0]  l_idx, f_idx, prev_idx;
  logic [SLOT_W-1:0] l_slot, f_slot;
  logic [TAG_W-1:0]  l_tag, f_tag;
  logic [LINE_W-1:0] l_line, prev_line;
  logic              prev_hit, f_match;

  assign l_idx  = IDX_W'(pc_field(lk_pc, LINE_LO, IDX_W));
  assign l_slot = SLOT_W'(pc_field(lk_pc, OFS_W, SLOT_W));
  assign l_tag  = TAG_W'(pc_field(lk_pc, TAG_LO, TAG_W));
  assign l_line = LINE_W'(pc_field(lk_pc, LINE_LO, LINE_W));
  assign f_idx  = IDX_W'(pc_field(fl_pc, LINE_LO, IDX_W));
  assign f_slot = SLOT_W'(pc_field(fl_pc, OFS_W, SLOT_W));
  assign f_tag  = TAG_W'(pc_field(fl_pc, TAG_LO, TAG_W));

  assign hit  = lk_v && sect_v[l_idx] && (sect_tag[l_idx] == l_tag) && slot_v[l_idx][l_slot];
  assign word = hit ? words[l_idx][l_slot] : '0;
  assign nxt  = hit ? sect_next[l_idx] : '0;

  assign f_match     = sect_v[f_idx] && (sect_tag[f_idx] == f_tag);
  assign evt_replace = fl_v && !f_match;
  assign evt_link    = lk_v && prev_hit && (l_line != prev_line) &&
                       !(fl_v && (f_idx == prev_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      sect_v   <= '0;
      prev_hit <= 1'b0;
    end else begin
      if (lk_v) begin
        prev_hit  <= hit;
        prev_idx  <= l_idx;
        prev_line <= l_line;
      end
      if (evt_link) sect_next[prev_idx] <= lk_pc;
      if (fl_v) begin
        sect_v[f_idx]   <= 1'b1;
        sect_tag[f_idx] <= f_tag;
        if (evt_replace) begin
          slot_v[f_idx]    <= SLOTS'(1) << f_slot;
          sect_next[f_idx] <= '0;
        end else begin
          slot_v[f_idx][f_slot] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fl_v) words[f_idx][f_slot] <= fl_word;
  end
endmodule

// File: rtl/dfc_steer.sv
module dfc_steer
  import dfc_pkg::*;
#(
  parameter int TAG_LO = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic lk_v,
  input  pc_t  lk_pc,
  output logic steer
);
  localparam int TAG_W = PC_W - TAG_LO;

  logic             have_prev;
  logic [TAG_W-1:0] prev_tag, cur_tag;

  assign cur_tag = TAG_W'(pc_field(lk_pc, TAG_LO, TAG_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      steer     <= 1'b0;
    end else if (lk_v) begin
      steer     <= have_prev && (cur_tag == prev_tag);
      prev_tag  <= cur_tag;
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/dfc_stats.sv
module dfc_stats #(
  parameter int NUM   = 5,
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dfc_top.sv
module dfc_top
  import dfc_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int SLOT_W = 2,
  parameter int OFS_W  = 2,
  parameter int WORD_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_valid,
  input  logic [31:0]       lookup_pc,
  output logic              hit_o,
  output logic [WORD_W-1:0] word_o,
  output logic [31:0]       next_pc_o,
  output logic              steer_dfc_o,
  input  logic              fill_valid,
  input  logic [31:0]       fill_pc,
  input  logic [WORD_W-1:0] fill_word,
  output logic [CNT_W-1:0]  cnt_access_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_miss_o,
  output logic [CNT_W-1:0]  cnt_pred_ok_o,
  output logic [CNT_W-1:0]  cnt_pred_bad_o
);
  localparam int TAG_LO = OFS_W + SLOT_W + IDX_W;

  logic                          evt_replace, evt_link;
  logic                          evt_pred_ok;
  logic [NUM_CNT-1:0]            cnt_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_bus;

  dfc_sectors #(
    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .OFS_W(OFS_W), .WORD_W(WORD_W)
  ) u_sectors (
    .clk(clk), .rst(rst),
    .lk_v(lookup_valid), .lk_pc(lookup_pc),
    .fl_v(fill_valid), .fl_pc(fill_pc), .fl_word(fill_word),
    .hit(hit_o), .word(word_o), .nxt(next_pc_o),
    .evt_replace(evt_replace), .evt_link(evt_link)
  );

  dfc_steer #(.TAG_LO(TAG_LO)) u_steer (
    .clk(clk), .rst(rst), .lk_v(lookup_valid), .lk_pc(lookup_pc), .steer(steer_dfc_o)
  );

  assign evt_pred_ok        = (steer_dfc_o == hit_o);
  assign cnt_inc[CNT_ACC]   = lookup_valid;
  assign cnt_inc[CNT_HIT]   = hit_o;
  assign cnt_inc[CNT_MISS]  = lookup_valid && !hit_o;
  assign cnt_inc[CNT_POK]   = lookup_valid && evt_pred_ok;
  assign cnt_inc[CNT_PBAD]  = lookup_valid && !evt_pred_ok;

  dfc_stats #(.NUM(NUM_CNT), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .inc(cnt_inc), .cnt(cnt_bus)
  );

  assign cnt_access_o   = cnt_bus[CNT_ACC];
  assign cnt_hit_o      = cnt_bus[CNT_HIT];
  assign cnt_miss_o     = cnt_bus[CNT_MISS];
  assign cnt_pred_ok_o  = cnt_bus[CNT_POK];
  assign cnt_pred_bad_o = cnt_bus[CNT_PBAD];
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker
  import dfc_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int OFS_W  = 2,
  parameter int WORD_W = 64,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lookup_valid,
  input logic [31:0]       lookup_pc,
  input logic              fill_valid,
  input logic [31:0]       fill_pc,
  input logic [WORD_W-1:0] fill_word,
  input logic              hit_o,
  input logic [WORD_W-1:0] word_o,
  input logic [31:0]       next_pc_o,
  input logic              steer_dfc_o,
  input logic              evt_replace,
  input logic [CNT_W-1:0]  cnt_access_o,
  input logic [CNT_W-1:0]  cnt_hit_o,
  input logic [CNT_W-1:0]  cnt_miss_o,
  input logic [CNT_W-1:0]  cnt_pred_ok_o,
  input logic [CNT_W-1:0]  cnt_pred_bad_o
);
  localparam int LINE_LO = OFS_W + SLOT_W;

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  a_r1_reset_state: assert property (@(posedge clk)
    (past_ok && $past(rst)) |-> (!steer_dfc_o && cnt_access_o == '0 && cnt_pred_bad_o == '0));

  a_r3_hit_needs_lookup: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> lookup_valid);

  a_r4_miss_outputs_zero: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (word_o == '0 && next_pc_o == '0));

  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
    fill_valid ##1 (lookup_valid && lookup_pc[31:OFS_W] == $past(fill_pc[31:OFS_W]))
      |-> (hit_o && word_o == $past(fill_word)));

  a_r6_replace_clears: assert property (@(posedge clk) disable iff (rst)
    evt_replace ##1 (lookup_valid &&
                     pc_field(lookup_pc, LINE_LO, PC_W - LINE_LO) ==
                       pc_field($past(fill_pc), LINE_LO, PC_W - LINE_LO) &&
                     pc_field(lookup_pc, OFS_W, SLOT_W) != pc_field($past(fill_pc), OFS_W, SLOT_W))
      |-> !hit_o);

  a_r7_steer_holds: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> $stable(steer_dfc_o));

  a_r9_access_step: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> cnt_access_o == $past(cnt_access_o) + CNT_W'(1));

  a_r9_hit_miss_sum: assert property (@(posedge clk) disable iff (rst)
    cnt_hit_o + cnt_miss_o == cnt_access_o);

  a_r10_pred_sum: assert property (@(posedge clk) disable iff (rst)
    cnt_pred_ok_o + cnt_pred_bad_o == cnt_access_o);
endmodule

bind dfc_top dfc_checker #(
  .SLOT_W(SLOT_W), .OFS_W(OFS_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_dfc_checker (
  .clk(clk), .rst(rst),
  .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
  .fill_valid(fill_valid), .fill_pc(fill_pc), .fill_word(fill_word),
  .hit_o(hit_o), .word_o(word_o), .next_pc_o(next_pc_o),
  .steer_dfc_o(steer_dfc_o), .evt_replace(evt_replace),
  .cnt_access_o(cnt_access_o), .cnt_hit_o(cnt_hit_o), .cnt_miss_o(cnt_miss_o),
  .cnt_pred_ok_o(cnt_pred_ok_o), .cnt_pred_bad_o(cnt_pred_bad_o)
);

// File: tb/test_dfc_top.sv
module test_dfc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0, fill_valid = 1'b0;
  logic [31:0] lookup_pc = '0, fill_pc = '0;
  logic [63:0] fill_word = '0;
  logic        hit_o, steer_dfc_o;
  logic [63:0] word_o;
  logic [31:0] next_pc_o;
  logic [31:0] cnt_access_o, cnt_hit_o, cnt_miss_o, cnt_pred_ok_o, cnt_pred_bad_o;

  int total = 0, bad = 0;
  bit done = 0;

  // shadow model
  bit          m_sv [32];
  int unsigned m_tag [32];
  bit          m_slv [32][4];
  logic [63:0] m_word [32][4];
  logic [31:0] m_nx [32];
  bit          m_steer, m_have, m_phit;
  int unsigned m_ptag, m_pidx, m_pline;
  int unsigned m_acc, m_hit, m_miss, m_pok, m_pbad;

  always #10 clk = ~clk;

  dfc_top i_dfc_top (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
    .hit_o(hit_o), .word_o(word_o), .next_pc_o(next_pc_o), .steer_dfc_o(steer_dfc_o),
    .fill_valid(fill_valid), .fill_pc(fill_pc), .fill_word(fill_word),
    .cnt_access_o(cnt_access_o), .cnt_hit_o(cnt_hit_o), .cnt_miss_o(cnt_miss_o),
    .cnt_pred_ok_o(cnt_pred_ok_o), .cnt_pred_bad_o(cnt_pred_bad_o)
  );

  function automatic int unsigned f_idx(input logic [31:0] pc);  return (pc / 16) % 32; endfunction
  function automatic int unsigned f_slot(input logic [31:0] pc); return (pc / 4) % 4;   endfunction
  function automatic int unsigned f_tag(input logic [31:0] pc);  return pc / 512;       endfunction
  function automatic int unsigned f_line(input logic [31:0] pc); return pc / 16;        endfunction
  function automatic logic [31:0] mk_pc(input int unsigned t, input int unsigned i, input int unsigned s);
    return t * 512 + i * 16 + s * 4;
  endfunction
  function automatic logic [63:0] mk_word(input logic [31:0] pc, input int unsigned salt);
    return {pc * 3 + salt, ~pc};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_sv[i] = 0;
    m_steer = 0; m_have = 0; m_phit = 0;
    m_acc = 0; m_hit = 0; m_miss = 0; m_pok = 0; m_pbad = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; lookup_valid = 0; fill_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  // One cycle: optional lookup and optional fill, driven after a falling edge.
  task automatic op(input bit dl, input logic [31:0] lpc, input bit df,
                    input logic [31:0] fpc, input logic [63:0] fw, input string rq);
    bit          eh;
    int unsigned li, ls;
    @(negedge clk);
    chk(steer_dfc_o == m_steer, "R7 steer", 64'(steer_dfc_o), 64'(m_steer));
    lookup_valid = dl; lookup_pc = lpc;
    fill_valid = df; fill_pc = fpc; fill_word = fw;
    #2;
    li = f_idx(lpc); ls = f_slot(lpc);
    eh = dl && m_sv[li] && m_tag[li] == f_tag(lpc) && m_slv[li][ls];
    chk(hit_o == eh, {rq, " hit"}, 64'(hit_o), 64'(eh));
    chk(word_o == (eh ? m_word[li][ls] : 64'd0), {rq, " word"}, word_o, eh ? m_word[li][ls] : 64'd0);
    chk(next_pc_o == (eh ? m_nx[li] : 32'd0), "R8 next", 64'(next_pc_o), 64'(eh ? m_nx[li] : 32'd0));
    // state change at the rising edge that closes this cycle
    if (dl) begin
      m_acc++;
      if (eh) m_hit++; else m_miss++;
      if (m_steer == eh) m_pok++; else m_pbad++;
      if (m_phit && f_line(lpc) != m_pline && !(df && f_idx(fpc) == m_pidx)) m_nx[m_pidx] = lpc;
      m_steer = m_have && f_tag(lpc) == m_ptag;
      m_ptag = f_tag(lpc); m_have = 1;
      m_phit = eh; m_pidx = li; m_pline = f_line(lpc);
    end
    if (df) begin
      int unsigned fi, fs;
      fi = f_idx(fpc); fs = f_slot(fpc);
      if (!(m_sv[fi] && m_tag[fi] == f_tag(fpc))) begin
        for (int k = 0; k < 4; k++) m_slv[fi][k] = 0;
        m_nx[fi] = '0;
      end
      m_sv[fi] = 1; m_tag[fi] = f_tag(fpc);
      m_slv[fi][fs] = 1; m_word[fi][fs] = fw;
    end
  endtask

  task automatic look(input logic [31:0] pc, input string rq);
    op(1, pc, 0, '0, '0, rq);
  endtask
  task automatic fill(input logic [31:0] pc, input logic [63:0] w, input string rq);
    op(0, '0, 1, pc, w, rq);
  endtask

  task automatic check_counters(input string rq);
    @(negedge clk);
    lookup_valid = 0; fill_valid = 0;
    @(negedge clk);
    chk(steer_dfc_o == m_steer, "R7 steer idle", 64'(steer_dfc_o), 64'(m_steer));
    chk(cnt_access_o == m_acc,   {rq, " R9 access"}, 64'(cnt_access_o), 64'(m_acc));
    chk(cnt_hit_o == m_hit,      {rq, " R9 hits"},   64'(cnt_hit_o),    64'(m_hit));
    chk(cnt_miss_o == m_miss,    {rq, " R9 misses"}, 64'(cnt_miss_o),   64'(m_miss));
    chk(cnt_pred_ok_o == m_pok,  {rq, " R10 ok"},    64'(cnt_pred_ok_o), 64'(m_pok));
    chk(cnt_pred_bad_o == m_pbad, {rq, " R10 bad"},  64'(cnt_pred_bad_o), 64'(m_pbad));
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1: reset state
    check_counters("R1");
    look(mk_pc(32'h200, 0, 0), "R1 first lookup");
    // fill every sector and instruction with tag A
    for (int i = 0; i < 32; i++)
      for (int s = 0; s < 4; s++)
        fill(mk_pc(32'h200, i, s), mk_word(mk_pc(32'h200, i, s), 1), "R6 fill");
    // two sweeps of lookups: first learns next addresses, second shows them (R3, R8)
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 32; i++)
        for (int s = 0; s < 4; s++)
          look(mk_pc(32'h200, i, s), "R3 sweep");
    check_counters("sweep");
    // R2: byte offset bits are ignored
    for (int b = 0; b < 4; b++) look(mk_pc(32'h200, 9, 2) + b, "R2 offset");
    // R6: different tag takes over sector 5
    fill(mk_pc(32'h201, 5, 2), mk_word(mk_pc(32'h201, 5, 2), 7), "R6 replace");
    look(mk_pc(32'h200, 5, 0), "R6 old tag");
    look(mk_pc(32'h201, 5, 0), "R6 cleared slot");
    look(mk_pc(32'h201, 5, 2), "R6 new word");
    // R5: same-tag fill keeps other instructions
    fill(mk_pc(32'h201, 5, 1), mk_word(mk_pc(32'h201, 5, 1), 9), "R5 merge");
    look(mk_pc(32'h201, 5, 2), "R5 kept");
    look(mk_pc(32'h201, 5, 1), "R5 added");
    fill(mk_pc(32'h201, 5, 1), mk_word(mk_pc(32'h201, 5, 1), 11), "R5 overwrite");
    look(mk_pc(32'h201, 5, 1), "R5 overwritten");
    // R11: lookup and fill together on the same sector
    op(1, mk_pc(32'h200, 7, 0), 1, mk_pc(32'h3ff, 7, 0), mk_word(mk_pc(32'h3ff, 7, 0), 3), "R11 old view");
    look(mk_pc(32'h200, 7, 0), "R11 after");
    look(mk_pc(32'h3ff, 7, 0), "R11 new");
    // R8: fill on the linked sector in the same cycle wins
    look(mk_pc(32'h200, 12, 0), "R8 setup");
    op(1, mk_pc(32'h200, 20, 0), 1, mk_pc(32'h200, 12, 3), mk_word(mk_pc(32'h200, 12, 3), 5), "R8 collide");
    look(mk_pc(32'h200, 12, 1), "R8 unchanged link");
    // R7/R10: alternating tags steer to the instruction cache
    for (int k = 0; k < 8; k++)
      look(mk_pc((k % 2 == 0) ? 32'h200 : 32'h201, 5, 2), "R7 alternate");
    // idle cycles keep the steering value
    look(mk_pc(32'h200, 3, 0), "R7 prime");
    look(mk_pc(32'h200, 3, 1), "R7 same tag");
    check_counters("final");
    // reset again mid-run
    do_reset();
    check_counters("R1 second");
    look(mk_pc(32'h200, 3, 1), "R1 invalid after reset");
    check_counters("R1 end");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule